// File: doc/BRIEF.md
# System Tick Compare Timer

This block keeps a free-running tick counter and two compare registers against it. The supervisor compare asks, for one cycle, for bit 16 of a separate soft-interrupt register to be set. The hypervisor compare sets a sticky pending bit, and that bit drives a hypervisor interrupt line. The compare registers are as wide as the counter plus one. The top bit of a compare register is a disable flag. The remaining bits hold the tick value to match.

Writing a compare register arms it only when the target is still ahead of the counter and the disable flag is clear. An armed comparator fires once at its target and then disarms. A later write to the same comparator replaces or cancels the armed target. A per-thread halted input makes a hypervisor match pass without effect. The soft-interrupt register itself and trap delivery are outside this block.

Top module: `tick_cmp_timer`

## Requirements
- R1: The counter (TICK_W-1 bits) is zero after reset and increases by one on every clock. It wraps from all-ones to zero. Reading select 3 returns it zero-extended. A write to select 3 changes nothing.
- R2: After reset, both compare registers read as only the top bit set, the pending bit reads 0, and soft_set_req and hyp_irq are low.
- R3: A write to select 0 (supervisor compare) or select 1 (hypervisor compare) stores the full word, and a read of the same select returns it unchanged.
- R4: A compare write arms its comparator only if bit TICK_W-1 of the data is 0 and the low bits are strictly greater than the counter at the write edge. A target equal to or below the counter, or a disabled write, never fires, even after the counter wraps.
- R5: A compare write with bit TICK_W-1 set cancels any earlier armed target of that comparator.
- R6: A new compare write replaces the earlier armed target, and only the new target fires.
- R7: When the counter equals an armed supervisor target, soft_set_req is high for exactly the one following cycle, while the counter equals target+1.
- R8: Each arming write yields at most one match. The comparator disarms when it fires, and it does not fire again when the counter wraps back to the target.
- R9: When the counter equals an armed hypervisor target, the pending bit is set and hyp_irq is high from the following cycle, while the counter equals target+1.
- R10: A hypervisor match while thread_halted is high does not set the pending bit. It still consumes the armed target.
- R11: A write to select 2 sets the pending bit to 1 for nonzero data and to 0 for zero data. A read of select 2 returns the bit in bit 0, and hyp_irq follows the bit. A hypervisor match in the same cycle as a write wins and leaves the bit at 1.
- R12: A write to a comparator in the cycle where its old target matches suppresses the old match. The new write's arming rule applies instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 supervisor compare, 1 hypervisor compare, 2 pending bit, 3 counter (ignored) |
| wr_data | input | TICK_W | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | TICK_W | Combinational read data |
| thread_halted | input | 1 | Thread halted; masks hypervisor matches |
| soft_set_req | output | 1 | One-cycle request to set soft-interrupt bit 16 |
| hyp_irq | output | 1 | Hypervisor interrupt request, equal to the pending bit |

## Verification
The assertions assume that wr_en, wr_sel, wr_data and thread_halted are known and stable around each rising edge, and that reset is held for at least one edge. The stimulus changes every input only on falling edges. It computes each compare target from a counter model of its own, and it picks the arming moment so that a target meant to lie in the future does not wrap past the counter's top. Cases with an equal target, a past target or a disabled target are made on purpose.

// File: rtl/tick_cmp_pkg.sv
`timescale 1ns/1ps
package tick_cmp_pkg;
  typedef enum logic [1:0] {
    SEL_SYS_CMP  = 2'd0,
    SEL_HYP_CMP  = 2'd1,
    SEL_HYP_PEND = 2'd2,
    SEL_TICK     = 2'd3
  } reg_sel_e;

  // A target arms only when enabled and strictly ahead of the counter.
  function automatic logic arm_ok(input logic dis, input logic [63:0] target,
                                  input logic [63:0] now);
    return !dis && (target > now);
  endfunction
endpackage

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
module tick_counter #(
  parameter int TICK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-2:0] tick
);
  localparam int MW = TICK_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= '0;
    else        tick <= tick + MW'(1);
  end
endmodule

// File: rtl/tick_cmp_unit.sv
`timescale 1ns/1ps
module tick_cmp_unit
  import tick_cmp_pkg::*;
#(
  parameter int TICK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [TICK_W-1:0] wr_data,
  input  logic [TICK_W-2:0] tick,
  input  logic              block,
  output logic [TICK_W-1:0] cmp_q,
  output logic              armed,
  output logic              fire
);
  localparam int MW = TICK_W - 1;
  localparam logic [TICK_W-1:0] CMP_RST = {1'b1, {MW{1'b0}}};

  logic match;
  logic consume;

  assign match   = armed && (tick == cmp_q[MW-1:0]) && !cmp_q[MW];
  assign consume = match && !wr_hit;
  assign fire    = consume && !block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= CMP_RST;
      armed <= 1'b0;
    end else if (wr_hit) begin
      cmp_q <= wr_data;
      armed <= arm_ok(wr_data[MW], 64'(wr_data[MW-1:0]), 64'(tick));
    end else if (consume) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/hyp_pend_reg.sv
`timescale 1ns/1ps
module hyp_pend_reg #(
  parameter int TICK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic              wr_hit,
  input  logic [TICK_W-1:0] wr_val,
  output logic              pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= 1'b0;
    else if (set)    pend <= 1'b1;
    else if (wr_hit) pend <= |wr_val;
  end
endmodule

// File: rtl/tick_cmp_timer.sv
`timescale 1ns/1ps
module tick_cmp_timer
  import tick_cmp_pkg::*;
#(
  parameter int TICK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TICK_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [TICK_W-1:0] rd_data,
  input  logic              thread_halted,
  output logic              soft_set_req,
  output logic              hyp_irq
);
  localparam int NCMP = 2;

  logic [TICK_W-2:0] tick_now;
  logic [TICK_W-1:0] cmp_q [NCMP];
  logic [NCMP-1:0]   armed_vec;
  logic [NCMP-1:0]   fire_vec;
  logic              sys_fire, hyp_fire, sys_armed, hyp_armed;
  logic              pend_q;

  tick_counter #(.TICK_W(TICK_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_now)
  );

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
    localparam logic [1:0] USEL = (gi == 0) ? SEL_SYS_CMP : SEL_HYP_CMP;
    tick_cmp_unit #(.TICK_W(TICK_W)) u_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_en && (wr_sel == USEL)),
      .wr_data(wr_data),
      .tick   (tick_now),
      .block  ((gi == 1) ? thread_halted : 1'b0),
      .cmp_q  (cmp_q[gi]),
      .armed  (armed_vec[gi]),
      .fire   (fire_vec[gi])
    );
  end

  assign sys_fire  = fire_vec[0];
  assign hyp_fire  = fire_vec[1];
  assign sys_armed = armed_vec[0];
  assign hyp_armed = armed_vec[1];

  hyp_pend_reg #(.TICK_W(TICK_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hyp_fire),
    .wr_hit(wr_en && (wr_sel == SEL_HYP_PEND)),
    .wr_val(wr_data),
    .pend  (pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) soft_set_req <= 1'b0;
    else        soft_set_req <= sys_fire;
  end

  assign hyp_irq = pend_q;

  always_comb begin
    case (rd_sel)
      SEL_SYS_CMP:  rd_data = cmp_q[0];
      SEL_HYP_CMP:  rd_data = cmp_q[1];
      SEL_HYP_PEND: rd_data = TICK_W'(pend_q);
      default:      rd_data = {1'b0, tick_now};
    endcase
  end
endmodule

// File: rtl/tick_cmp_checker.sv
`timescale 1ns/1ps
module tick_cmp_checker #(
  parameter int TICK_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [TICK_W-1:0] wr_data,
  input logic              thread_halted,
  input logic              soft_set_req,
  input logic              hyp_irq,
  input logic [TICK_W-2:0] tick_now,
  input logic              sys_fire,
  input logic              hyp_fire,
  input logic              sys_armed,
  input logic              hyp_armed
);
  localparam int MW = TICK_W - 1;

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tick_now == $past(tick_now) + MW'(1));

  assert_soft_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_set_req |=> !soft_set_req);

  assert_soft_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && soft_set_req) |-> $past(sys_fire));

  assert_sys_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en && wr_sel == 2'd0 && wr_data[MW])) |-> !sys_armed);

  assert_hyp_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en && wr_sel == 2'd1 && wr_data[MW])) |-> !hyp_armed);

  assert_sys_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_fire |=> !sys_armed);

  assert_hyp_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_fire |=> !hyp_armed);

  assert_hyp_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hyp_fire)) |-> hyp_irq);

  assert_halt_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_fire |-> !thread_halted);

  assert_pend_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en && wr_sel == 2'd2 && wr_data == '0 && !hyp_fire))
      |-> !hyp_irq);
endmodule

bind tick_cmp_timer tick_cmp_checker #(.TICK_W(TICK_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .thread_halted(thread_halted),
  .soft_set_req (soft_set_req),
  .hyp_irq      (hyp_irq),
  .tick_now     (tick_now),
  .sys_fire     (sys_fire),
  .hyp_fire     (hyp_fire),
  .sys_armed    (sys_armed),
  .hyp_armed    (hyp_armed)
);

// File: tb/sim_tick_cmp_timer.sv
`timescale 1ns/1ps
module sim_tick_cmp_timer;
  localparam int W  = 12;
  localparam int MW = W - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] rd_sel = 2'd3;
  logic [W-1:0] rd_data;
  logic thread_halted = 1'b0;
  logic soft_set_req, hyp_irq;

  int checks = 0;
  int errs = 0;
  bit done = 0;
  logic [MW-1:0] m;
  logic [MW-1:0] soft_q[$];
  logic [MW-1:0] hyp_q[$];
  logic hyp_prev = 1'b0;

  always #2 clk = ~clk;

  tick_cmp_timer #(.TICK_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .thread_halted(thread_halted),
    .soft_set_req(soft_set_req), .hyp_irq(hyp_irq)
  );

  // Independent counter model.
  always @(posedge clk) begin
    if (!rst_n) m <= '0;
    else        m <= m + MW'(1);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
    rd_sel = s;
    #0.5;
    v = rd_data;
  endtask

  // Writes at the next edge; counter at that edge is returned in c.
  task automatic wr(input logic [1:0] s, input logic [W-1:0] d, output logic [MW-1:0] c);
    @(negedge clk);
    c = m;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Arms a comparator at counter+off, waiting for a window free of wrap.
  task automatic arm(input logic [1:0] s, input int off, input bit dis,
                     input bit push, output logic [MW-1:0] v);
    do @(negedge clk); while (m < 8 || m > 1900);
    v = MW'(int'(m) + off);
    wr_en = 1'b1; wr_sel = s; wr_data = {dis, v};
    if (push) begin
      if (s == 2'd0) soft_q.push_back(v + MW'(1));
      else           hyp_q.push_back(v + MW'(1));
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (soft_set_req) begin
          if (soft_q.size() == 0) chk("R7 unexpected soft_set_req at tick", 64'(m), 64'hFFFF);
          else chk("R7 soft_set_req tick", 64'(m), 64'(soft_q.pop_front()));
        end
        if (hyp_irq && !hyp_prev) begin
          if (hyp_q.size() == 0) chk("R9 unexpected hyp_irq rise at tick", 64'(m), 64'hFFFF);
          else chk("R9 hyp_irq rise tick", 64'(m), 64'(hyp_q.pop_front()));
        end
        hyp_prev = hyp_irq;
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [W-1:0] v;
    logic [MW-1:0] c, t, t2;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    rd(2'd0, v); chk("R2 sys cmp reset", 64'(v), 64'h800);
    rd(2'd1, v); chk("R2 hyp cmp reset", 64'(v), 64'h800);
    rd(2'd2, v); chk("R2 pend reset", 64'(v), 64'h0);
    chk("R2 soft_set_req reset", 64'(soft_set_req), 64'h0);
    chk("R2 hyp_irq reset", 64'(hyp_irq), 64'h0);
    rd(2'd3, v); chk("R1 tick after reset", 64'(v), 64'(m));
    // R3 readback
    wr(2'd0, 12'h8AB, c);
    @(negedge clk); rd(2'd0, v); chk("R3 sys cmp readback", 64'(v), 64'h8AB);
    wr(2'd1, 12'hFFF, c);
    @(negedge clk); rd(2'd1, v); chk("R3 hyp cmp readback", 64'(v), 64'hFFF);
    // R1 write to counter select ignored
    wr(2'd3, 12'h000, c);
    @(negedge clk); rd(2'd3, v); chk("R1 tick unaffected by write", 64'(v), 64'(m));
    // R7 supervisor match, far and next-cycle targets
    arm(2'd0, 10, 1'b0, 1'b1, t);
    repeat (20) @(negedge clk);
    chk("R7 soft pulse consumed", 64'(soft_q.size()), 64'h0);
    arm(2'd0, 1, 1'b0, 1'b1, t);
    repeat (5) @(negedge clk);
    chk("R7 next-cycle target consumed", 64'(soft_q.size()), 64'h0);
    // R9 / R11 hypervisor match and pending bit
    arm(2'd1, 7, 1'b0, 1'b1, t);
    repeat (12) @(negedge clk);
    chk("R9 hyp_irq high", 64'(hyp_irq), 64'h1);
    rd(2'd2, v); chk("R11 pend reads 1", 64'(v), 64'h1);
    wr(2'd2, 12'h000, c);
    chk("R11 write zero clears hyp_irq", 64'(hyp_irq), 64'h0);
    @(negedge clk); hyp_q.push_back(m + MW'(1));
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 12'h005;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd2, v); chk("R11 nonzero write sets pend", 64'(v), 64'h1);
    wr(2'd2, 12'h000, c);
    rd(2'd2, v); chk("R11 pend cleared", 64'(v), 64'h0);
    // R4 equal, past and disabled targets never fire
    arm(2'd0, 0, 1'b0, 1'b0, t);
    arm(2'd1, -3, 1'b0, 1'b0, t);
    repeat (2100) @(negedge clk);
    chk("R4 no pulse for equal/past target", 64'(soft_q.size() + hyp_q.size()), 64'h0);
    chk("R4 hyp_irq stays low", 64'(hyp_irq), 64'h0);
    arm(2'd0, 15, 1'b1, 1'b0, t);
    repeat (25) @(negedge clk);
    chk("R4 disabled target no pulse", 64'(soft_set_req), 64'h0);
    // R5 cancel by disable write
    arm(2'd0, 20, 1'b0, 1'b0, t);
    wr(2'd0, {1'b1, t}, c);
    repeat (30) @(negedge clk);
    chk("R5 cancelled target silent", 64'(soft_set_req), 64'h0);
    // R6 replacement
    arm(2'd0, 10, 1'b0, 1'b0, t);
    arm(2'd0, 25, 1'b0, 1'b1, t2);
    repeat (40) @(negedge clk);
    chk("R6 only replacement fired", 64'(soft_q.size()), 64'h0);
    // R12 write in the old target's match cycle
    arm(2'd0, 6, 1'b0, 1'b0, t);
    do @(negedge clk); while (m != t);
    t2 = m + MW'(3);
    soft_q.push_back(t2 + MW'(1));
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = {1'b0, t2};
    @(negedge clk); wr_en = 1'b0;
    chk("R12 old match suppressed", 64'(soft_set_req), 64'h0);
    repeat (10) @(negedge clk);
    chk("R12 new target fired", 64'(soft_q.size()), 64'h0);
    // R10 halted masks and consumes hypervisor match
    thread_halted = 1'b1;
    arm(2'd1, 8, 1'b0, 1'b0, t);
    repeat (15) @(negedge clk);
    chk("R10 no pend while halted", 64'(hyp_irq), 64'h0);
    thread_halted = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd2, v); chk("R10 match consumed", 64'(v), 64'h0);
    // R11 match beats concurrent write of zero
    arm(2'd1, 6, 1'b0, 1'b1, t);
    do @(negedge clk); while (m != t);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = '0;
    @(negedge clk); wr_en = 1'b0;
    chk("R11 match wins over write zero", 64'(hyp_irq), 64'h1);
    wr(2'd2, 12'h000, c);
    // R1 wrap and R8 single fire across wrap
    arm(2'd0, 5, 1'b0, 1'b1, t);
    do @(negedge clk); while (m != MW'(2047));
    rd(2'd3, v); chk("R1 tick at top", 64'(v), 64'h7FF);
    @(negedge clk);
    rd(2'd3, v); chk("R1 tick wrapped to zero", 64'(v), 64'h0);
    do @(negedge clk); while (m != t + MW'(20));
    chk("R8 no refire after wrap", 64'(soft_q.size() + hyp_q.size()), 64'h0);
    chk("R8 soft_set_req low", 64'(soft_set_req), 64'h0);
    summary();
  end
endmodule